// File: doc/BRIEF.md
# Latched Status and Interrupt Controller

This block gathers supply, reset and bus event indications into a small set of byte-wide status registers. It drives one active-low interrupt line for a host processor. Most status bits are sticky: they are set by a one-cycle event strobe and cleared when software reads the register that holds them. The VBAT-high indication is different: it is a live copy of its input and no read can clear it.

Two mask registers choose which sources may raise the interrupt. Two merged source registers collect the interrupt-capable flags so that software can find the cause in one or two reads. These source registers only mirror flags that live elsewhere, so reading them leaves those flags untouched.

Access is through a plain register port with address, write strobe, write data, read strobe and registered read data. There is no back-pressure: every strobe is taken in the cycle it is presented, and read data appears one cycle later and holds until the next read. The external reset input, while low, clears both mask registers and records an external reset in the reset-source register.

Top module: `sts_irq_ctrl`

## Requirements
- R1: On power-on reset (`rst_n` low): `rdata` is 0, `irq_n` is 1 and both mask registers are 0. The first read of the reset-source register (0x1A) returns 0x05.
- R2: Reset-source register 0x1A layout: bit 0 is V1 undervoltage (`ev_v1_uv`), bit 1 is watchdog reset (`ev_wdog`), bit 2 is external reset (`ext_rst_n` sampled low). Each bit latches when its event occurs. One read clears all three bits.
- R3: Supply register 0x1B layout: bit 3 is V3 overtemperature, bit 2 is V2 on, bit 1 is VBAT high and bit 0 is VBAT low. Bits 3, 2 and 0 latch on their strobes and clear on a read of 0x1B.
- R4: Bit 1 of 0x1B is the value of `vbat_high` sampled at the previous clock edge. A read never clears it.
- R5: Event register 0x20 layout: bit 0 is high-temperature warning, bit 1 is mid-temperature warning, bit 2 is bus failure, bit 3 is SPI error and bit 4 is wake-up. All five latch on their strobes and clear on a read of 0x20.
- R6: Mask register 0x1D holds HV, HTPW, MTPW and BATU in bits 3 down to 0. Mask register 0x1E holds BUSF, SPIE and WU in bits 2 down to 0. Both are written by `wr_en` and read back, and a 1 enables the source.
- R7: While `ext_rst_n` is low, both mask registers are cleared after the edge. This takes priority over a write in the same cycle.
- R8: Source register 0x21 layout: bit 3 is VBAT high (live), bit 2 is the high-temperature flag, bit 1 is the mid-temperature flag and bit 0 is the VBAT low flag. Source register 0x22 layout: bit 2 is bus failure, bit 1 is SPI error and bit 0 is wake-up. Reading 0x21 or 0x22 clears nothing.
- R9: `irq_n` is 0 exactly when some source bit in 0x21 or 0x22 is 1 and its mask bit in the same position of 0x1D or 0x1E is 1.
- R10: A read presented at clock edge E returns the register's value before E on `rdata` after E, and clears it after E. An event strobed at edge E stays set. `rdata` changes only on a read.
- R11: Unused bits read as 0. Unmapped addresses read as 0. Writes to any address other than 0x1D and 0x1E have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset input, active low, sampled |
| ev_v1_uv | input | 1 | V1 undervoltage event strobe |
| ev_wdog | input | 1 | Watchdog reset event strobe |
| vbat_low | input | 1 | VBAT low event strobe |
| vbat_high | input | 1 | VBAT high live level |
| v2_on | input | 1 | V2 on event strobe |
| v3_ot | input | 1 | V3 overtemperature event strobe |
| temp_hi_warn | input | 1 | High-temperature warning strobe |
| temp_mid_warn | input | 1 | Mid-temperature warning strobe |
| bus_fail | input | 1 | Bus failure strobe |
| spi_err | input | 1 | SPI error strobe |
| wake | input | 1 | Wake-up strobe |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Registered read data |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Every result is due exactly one edge after its cause. An event strobe, a live-level change, a mask write or an external reset is sampled at edge E and is visible in the registers and on `irq_n` after E. A read taken at E shows pre-E contents on `rdata` just after E, and its clear is visible from the next read on. The bench drives each cycle's inputs at the falling edge and samples one time unit after the rising edge. It advances its reference model by one edge per cycle with those same inputs, and compares `irq_n` every cycle and `rdata` on every read cycle.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int ADDR_W_DEF = 8;
  localparam int DATA_W_DEF = 8;

  localparam int A_RSTSRC = 'h1A;
  localparam int A_SUPPLY = 'h1B;
  localparam int A_MASK1  = 'h1D;
  localparam int A_MASK2  = 'h1E;
  localparam int A_EVENT  = 'h20;
  localparam int A_SRC1   = 'h21;
  localparam int A_SRC2   = 'h22;

  localparam int RST_BITS = 3;
  localparam int SUP_LAT  = 3;
  localparam int EVT_BITS = 5;
  localparam int M1_BITS  = 4;
  localparam int M2_BITS  = 3;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_RST  = 3'd1,
    SEL_SUP  = 3'd2,
    SEL_M1   = 3'd3,
    SEL_M2   = 3'd4,
    SEL_EVT  = 3'd5,
    SEL_S1   = 3'd6,
    SEL_S2   = 3'd7
  } reg_sel_e;

  localparam int NSEL = 8;

  function automatic reg_sel_e decode_addr(input int a);
    case (a)
      A_RSTSRC: return SEL_RST;
      A_SUPPLY: return SEL_SUP;
      A_MASK1:  return SEL_M1;
      A_MASK2:  return SEL_M2;
      A_EVENT:  return SEL_EVT;
      A_SRC1:   return SEL_S1;
      A_SRC2:   return SEL_S2;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sts_flag_bank.sv
module sts_flag_bank #(
  parameter int N = 4,
  parameter logic [N-1:0] POR_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= POR_VAL[i];
      else        q[i] <= (q[i] & ~clr) | set[i];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]) else $error("event lost"); // R10
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> (q == '0)) else $error("read did not clear"); // R2

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q & $past(q)) == $past(q))) else $error("flag dropped without read"); // R5
endmodule

// File: rtl/sts_mask_reg.sv
module sts_mask_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (!ext_rst_n) q <= '0;
    else if (we)        q <= wdata;
  end

  AST_MASK_EXT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n |=> (q == '0)) else $error("mask survived external reset"); // R7

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rst_n && !we) |=> $stable(q)) else $error("mask changed without write"); // R6
endmodule

// File: rtl/sts_read_port.sv
module sts_read_port
  import sts_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  reg_sel_e                    sel,
  input  logic [NSEL-1:0][DATA_W-1:0] vals,
  output logic [DATA_W-1:0]           rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= vals[sel];
  end

  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)) else $error("rdata moved without read"); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> (rdata == '0)) else $error("unmapped read nonzero"); // R11
endmodule

// File: rtl/sts_irq_ctrl.sv
module sts_irq_ctrl
  import sts_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst_n,
  input  logic              ev_v1_uv,
  input  logic              ev_wdog,
  input  logic              vbat_low,
  input  logic              vbat_high,
  input  logic              v2_on,
  input  logic              v3_ot,
  input  logic              temp_hi_warn,
  input  logic              temp_mid_warn,
  input  logic              bus_fail,
  input  logic              spi_err,
  input  logic              wake,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n
);
  reg_sel_e sel;
  assign sel = decode_addr(int'(addr));

  logic [RST_BITS-1:0] rst_q;
  logic [SUP_LAT-1:0]  sup_q;   // {v3_ot, v2_on, vbat_low}
  logic [EVT_BITS-1:0] evt_q;   // {wake, spi, bus, mid, hi}
  logic [M1_BITS-1:0]  m1_q;
  logic [M2_BITS-1:0]  m2_q;
  logic                hv_q;

  sts_flag_bank #(.N(RST_BITS), .POR_VAL(3'b101)) u_rst (
    .clk(clk), .rst_n(rst_n),
    .set({~ext_rst_n, ev_wdog, ev_v1_uv}),
    .clr(rd_en && sel == SEL_RST),
    .q(rst_q)
  );

  sts_flag_bank #(.N(SUP_LAT), .POR_VAL('0)) u_sup (
    .clk(clk), .rst_n(rst_n),
    .set({v3_ot, v2_on, vbat_low}),
    .clr(rd_en && sel == SEL_SUP),
    .q(sup_q)
  );

  sts_flag_bank #(.N(EVT_BITS), .POR_VAL('0)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .set({wake, spi_err, bus_fail, temp_mid_warn, temp_hi_warn}),
    .clr(rd_en && sel == SEL_EVT),
    .q(evt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_q <= 1'b0;
    else        hv_q <= vbat_high;
  end

  sts_mask_reg #(.N(M1_BITS)) u_m1 (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .we(wr_en && sel == SEL_M1), .wdata(wdata[M1_BITS-1:0]), .q(m1_q)
  );

  sts_mask_reg #(.N(M2_BITS)) u_m2 (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .we(wr_en && sel == SEL_M2), .wdata(wdata[M2_BITS-1:0]), .q(m2_q)
  );

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:M1_BITS];

  // merged source views: mirrors only
  logic [M1_BITS-1:0] src1;
  logic [M2_BITS-1:0] src2;
  assign src1 = {hv_q, evt_q[0], evt_q[1], sup_q[0]};
  assign src2 = {evt_q[2], evt_q[3], evt_q[4]};

  assign irq_n = ~(|(src1 & m1_q) | |(src2 & m2_q));

  logic [NSEL-1:0][DATA_W-1:0] vals;
  always_comb begin
    vals          = '0;
    vals[SEL_RST] = DATA_W'(rst_q);
    vals[SEL_SUP] = DATA_W'({sup_q[2], sup_q[1], hv_q, sup_q[0]});
    vals[SEL_M1]  = DATA_W'(m1_q);
    vals[SEL_M2]  = DATA_W'(m2_q);
    vals[SEL_EVT] = DATA_W'(evt_q);
    vals[SEL_S1]  = DATA_W'(src1);
    vals[SEL_S2]  = DATA_W'(src2);
  end

  sts_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel),
    .vals(vals), .rdata(rdata)
  );

  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_q == '0 && m2_q == '0) |-> irq_n) else $error("irq with all masks off"); // R9

  AST_SRC_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel == SEL_S1 || sel == SEL_S2)) |=>
      ((evt_q & $past(evt_q)) == $past(evt_q))) else $error("source read cleared flags"); // R8

  AST_LIVE_HV: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hv_q == $past(vbat_high))) else $error("live VBAT high stale"); // R4
endmodule

// File: tb/sts_irq_ctrl_test.sv
module sts_irq_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ext_rst_n, wr_en, rd_en;
  logic [10:0] ev;
  logic [7:0] addr, wdata, rdata;
  logic irq_n;

  sts_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .ev_v1_uv(ev[0]), .ev_wdog(ev[1]), .vbat_low(ev[2]), .vbat_high(ev[3]),
    .v2_on(ev[4]), .v3_ot(ev[5]), .temp_hi_warn(ev[6]), .temp_mid_warn(ev[7]),
    .bus_fail(ev[8]), .spi_err(ev[9]), .wake(ev[10]),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .irq_n(irq_n)
  );

  int errors = 0, checks = 0;
  logic [2:0] m_rst, m_sup;
  logic [4:0] m_evt;
  logic [3:0] m_m1;
  logic [2:0] m_m2;
  logic m_hv;
  logic [7:0] m_rdata;

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h1A: return {5'b0, m_rst};
      8'h1B: return {4'b0, m_sup[2], m_sup[1], m_hv, m_sup[0]};
      8'h1D: return {4'b0, m_m1};
      8'h1E: return {5'b0, m_m2};
      8'h20: return {3'b0, m_evt};
      8'h21: return {4'b0, m_hv, m_evt[0], m_evt[1], m_sup[0]};
      8'h22: return {5'b0, m_evt[2], m_evt[3], m_evt[4]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq_n();
    logic [3:0] s1;
    logic [2:0] s2;
    s1 = {m_hv, m_evt[0], m_evt[1], m_sup[0]};
    s2 = {m_evt[2], m_evt[3], m_evt[4]};
    return !((|(s1 & m_m1)) || (|(s2 & m_m2)));
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h1A: return "R2";
      8'h1B: return "R3";
      8'h1D, 8'h1E: return "R6";
      8'h20: return "R5";
      8'h21, 8'h22: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic was_rd;
    logic [7:0] a;
    @(posedge clk);
    #1;
    was_rd = rd_en;
    a = addr;
    if (was_rd) begin
      m_rdata = exp_read(a);
      case (a)
        8'h1A: m_rst = '0;
        8'h1B: m_sup = '0;
        8'h20: m_evt = '0;
        default: ;
      endcase
    end
    m_rst = m_rst | {~ext_rst_n, ev[1], ev[0]};
    m_sup = m_sup | {ev[5], ev[4], ev[2]};
    m_evt = m_evt | {ev[10], ev[9], ev[8], ev[7], ev[6]};
    m_hv = ev[3];
    if (!ext_rst_n) begin m_m1 = '0; m_m2 = '0; end
    else if (wr_en && a == 8'h1D) m_m1 = wdata[3:0];
    else if (wr_en && a == 8'h1E) m_m2 = wdata[2:0];
    check(tag == "" ? read_tag(a) : tag, rdata, m_rdata);
    check(tag == "" ? "R9" : tag, {7'b0, irq_n}, {7'b0, exp_irq_n()});
    @(negedge clk);
  endtask

  task automatic idle();
    ev = 11'b0; ev[3] = m_hv; rd_en = 0; wr_en = 0; ext_rst_n = 1;
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    rd_en = 1; addr = a; step(tag); idle();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    wr_en = 1; addr = a; wdata = d; step(tag); idle();
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; ext_rst_n = 1; ev = '0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
    m_rst = 3'b101; m_sup = 0; m_evt = 0; m_m1 = 0; m_m2 = 0; m_hv = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1", rdata, 8'h00);
    check("R1", {7'b0, irq_n}, 8'h01);
    @(negedge clk);
    do_read(8'h1D, "R1");
    do_read(8'h1A, "R1");                     // first read returns 101
    do_read(8'h1A, "R2");                     // now cleared
    ev[1] = 1; step("R2"); idle();
    do_read(8'h1A, "R2");
    ev[3] = 1; step("R4"); m_hv = 1; idle();
    do_read(8'h1B, "R4");
    do_read(8'h1B, "R4");                     // live bit survives read
    ev[8] = 1; rd_en = 1; addr = 8'h20; step("R10"); idle();
    do_read(8'h20, "R10");                    // same-cycle event kept
    ev[6] = 1; step("R5"); idle();
    do_write(8'h1D, 8'h04, "R9");
    do_read(8'h21, "R8");
    do_read(8'h21, "R8");                     // source read clears nothing
    do_write(8'h21, 8'hFF, "R11");
    do_write(8'h1A, 8'hFF, "R11");
    do_read(8'h1A, "R11");
    do_read(8'h40, "R11");
    do_read(8'h20, "R9");                     // clears high-temp, irq releases
    step("R9");
    do_write(8'h1E, 8'h07, "R6");
    do_read(8'h1E, "R6");
    ext_rst_n = 0; wr_en = 1; addr = 8'h1D; wdata = 8'h0F; step("R7"); idle();
    do_read(8'h1D, "R7");
    do_read(8'h1E, "R7");
    do_read(8'h1A, "R7");

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] alist [9];
      alist = '{8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'h1E, 8'h20, 8'h21, 8'h22, 8'h40};
      for (int b = 0; b < 11; b++) ev[b] = ($urandom % 20) == 0;
      ev[3] = (($urandom % 12) == 0) ? ~m_hv : m_hv;
      ext_rst_n = ($urandom % 60) != 0;
      rd_en = ($urandom % 3) == 0;
      wr_en = ($urandom % 6) == 0;
      addr = alist[$urandom % 9];
      wdata = 8'($urandom);
      step("");
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule